// File: doc/BRIEF.md
# Cascadable serial-to-parallel latch register

This block gathers a serial bit stream into a shift stage and, on command, copies the whole stage into a holding register that drives the parallel outputs. Because the shift stage and the holding register have separate strobes, a new word can be shifted in while the outputs keep showing the previous word. The new word appears on the outputs in one step when the latch strobe fires.

The last shift stage is brought out as a cascade bit. Feeding it into the serial input of a second instance builds a wider chain that shares the shift, latch, clear and enable controls. The whole block runs on one system clock. Shift and latch events arrive as one-cycle enable strobes.

An output-enable input controls a per-bit drive flag. The flag stands in for a three-state driver and leaves all internal state alone.

Top module: `sipo_latch_reg`

## Requirements
- R1: In a cycle with `shift_i` high and `clr_ni` high, the shift stage moves each bit one position toward the last stage (bit W-1), and `ser_i` enters bit 0.
- R2: In a cycle with `shift_i` low and `clr_ni` high, the shift stage keeps its value, whatever `ser_i` does.
- R3: In a cycle with `latch_i` high, the holding register takes the whole shift stage. `par_o` always shows the holding register.
- R4: When `shift_i` and `latch_i` are high in the same cycle, the holding register takes the shift-stage value from before that shift.
- R5: In a cycle with `clr_ni` low, the shift stage becomes all zeros, whatever `shift_i` is.
- R6: `clr_ni` does not change the holding register. Zeroing `par_o` takes a clear followed by a latch.
- R7: `cas_o` equals the last shift stage (bit W-1) and does not depend on `oe_ni`.
- R8: When `oe_ni` is low, every bit of `par_en_o` is 1. When `oe_ni` is high, every bit is 0. `oe_ni` has no effect on the shift stage, the holding register or `cas_o`.
- R9: While `rst_ni` is low, the shift stage and the holding register are zero, so `par_o` and `cas_o` read 0.
- R10: When `cas_o` of one instance drives `ser_i` of a second instance, 2W shifts place the first bit shifted in at bit W-1 of the second instance's shift stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | 1 | Serial data in |
| shift_i | input | 1 | One-cycle shift strobe |
| latch_i | input | 1 | One-cycle latch strobe |
| clr_ni | input | 1 | Shift-stage clear, active low, sampled on the clock |
| oe_ni | input | 1 | Output enable, active low |
| par_o | output | W | Holding register contents |
| par_en_o | output | W | Per-bit drive flag (1 = driven, 0 = released) |
| cas_o | output | 1 | Cascade output, last shift stage |

## Verification
The assertions assume that all control inputs are free of unknown values after reset and change only between clock edges. They also assume W is at least 2, so that a second-to-last stage exists.

The bench drives every input on the falling clock edge and holds the reset low for the first cycles. It then chains two instances with shared controls. It steps through serial patterns, separate and simultaneous shift and latch strobes, a clear in the middle of a stream, and toggling of the output enable. Outputs are compared with a queue-based model on every cycle.

// File: rtl/sipo_latch_pkg.sv
package sipo_latch_pkg;
  localparam int unsigned STAGE_W = 8;
  typedef enum logic {OUT_HIZ = 1'b0, OUT_DRIVE = 1'b1} drive_e;
endpackage

// File: rtl/sipo_shift_stage.sv
module sipo_shift_stage #(
  parameter int unsigned W = sipo_latch_pkg::STAGE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ser_i,
  input  logic         shift_i,
  input  logic         clr_ni,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (!clr_ni) q <= '0;
    else if (shift_i) q <= {q[W-2:0], ser_i};
  end

  assign q_o = q;

  a_r1_shift_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && clr_ni) |=> (q_o[W-1:1] == $past(q_o[W-2:0]) && q_o[0] == $past(ser_i)));
  a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && clr_ni) |=> $stable(q_o));
  a_r5_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> (q_o == '0));
endmodule

// File: rtl/sipo_hold_reg.sv
module sipo_hold_reg #(
  parameter int unsigned W = sipo_latch_pkg::STAGE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         latch_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (latch_i) q <= d_i;
  end

  assign q_o = q;

  a_r3_latch_copies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> (q_o == $past(d_i)));
  a_r6_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> $stable(q_o));
endmodule

// File: rtl/sipo_out_gate.sv
module sipo_out_gate #(
  parameter int unsigned W = sipo_latch_pkg::STAGE_W
) (
  input  logic         oe_ni,
  output logic [W-1:0] en_o
);
  import sipo_latch_pkg::*;

  drive_e mode;
  assign mode = oe_ni ? OUT_HIZ : OUT_DRIVE;

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign en_o[g] = (mode == OUT_DRIVE);
  end
endmodule

// File: rtl/sipo_latch_reg.sv
module sipo_latch_reg #(
  parameter int unsigned W = sipo_latch_pkg::STAGE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ser_i,
  input  logic         shift_i,
  input  logic         latch_i,
  input  logic         clr_ni,
  input  logic         oe_ni,
  output logic [W-1:0] par_o,
  output logic [W-1:0] par_en_o,
  output logic         cas_o
);
  localparam int unsigned LAST = W - 1;

  logic [W-1:0] sh_q;
  logic [W-1:0] hold_q;

  sipo_shift_stage #(.W(W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .ser_i(ser_i), .shift_i(shift_i),
    .clr_ni(clr_ni), .q_o(sh_q)
  );

  sipo_hold_reg #(.W(W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .latch_i(latch_i), .d_i(sh_q), .q_o(hold_q)
  );

  sipo_out_gate #(.W(W)) u_gate (
    .oe_ni(oe_ni), .en_o(par_en_o)
  );

  assign par_o = hold_q;
  assign cas_o = sh_q[LAST];

  a_r4_latch_pre_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && latch_i && clr_ni) |=> (par_o == {cas_o, $past(sh_q[W-2:0])} ^ {cas_o ^ $past(sh_q[LAST]), {(W-1){1'b0}}} ));
  a_r7_cascade_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && clr_ni) |=> (cas_o == $past(sh_q[W-2])));
  a_r8_enable_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni ? (par_en_o == '0) : ($countones(par_en_o) == W));
  a_r6_clear_keeps_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_ni && !latch_i) |=> $stable(par_o));
endmodule

// File: tb/tb_sipo_latch_reg.sv
`timescale 1ns/1ps
module tb_sipo_latch_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ser = 1'b0, shift = 1'b0, latch = 1'b0, clr_n = 1'b1, oe_n = 1'b0;
  logic [W-1:0] par_a, par_b, en_a, en_b;
  logic cas_a, cas_b;

  int checks = 0;
  int fails  = 0;
  string tag = "R9";

  bit chain_q[$];
  bit hold_q[$];

  always #2 clk = ~clk;

  sipo_latch_reg #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ser_i(ser), .shift_i(shift), .latch_i(latch),
    .clr_ni(clr_n), .oe_ni(oe_n), .par_o(par_a), .par_en_o(en_a), .cas_o(cas_a)
  );

  sipo_latch_reg #(.W(W)) dut_b (
    .clk_i(clk), .rst_ni(rst_ni), .ser_i(cas_a), .shift_i(shift), .latch_i(latch),
    .clr_ni(clr_n), .oe_ni(oe_n), .par_o(par_b), .par_en_o(en_b), .cas_o(cas_b)
  );

  task automatic check(input string t, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [W-1:0] ea, eb;
    for (int i = 0; i < W; i++) begin
      ea[i] = hold_q[i];
      eb[i] = hold_q[W+i];
    end
    check({tag, " par_a"}, par_a, ea);
    check({tag, " R10 par_b"}, par_b, eb);
    check("R7 cas_a", {{(W-1){1'b0}}, cas_a}, {{(W-1){1'b0}}, chain_q[W-1]});
    check("R7 R10 cas_b", {{(W-1){1'b0}}, cas_b}, {{(W-1){1'b0}}, chain_q[2*W-1]});
    check("R8 en_a", en_a, oe_n ? '0 : '1);
    check("R8 en_b", en_b, oe_n ? '0 : '1);
  endtask

  task automatic step(input logic s, input logic sh, input logic la, input logic cl, input logic oe);
    ser = s; shift = sh; latch = la; clr_n = cl; oe_n = oe;
    @(posedge clk);
    if (la) hold_q = chain_q;
    if (!cl) begin
      foreach (chain_q[i]) chain_q[i] = 1'b0;
    end else if (sh) begin
      chain_q.push_front(s);
      void'(chain_q.pop_back());
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [2*W-1:0] pat;
    for (int i = 0; i < 2*W; i++) begin
      chain_q.push_back(1'b0);
      hold_q.push_back(1'b0);
    end
    repeat (3) @(negedge clk);
    tag = "R9";
    compare_all();
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 R10: shift 16 bits through both, then latch
    tag = "R1";
    pat = 16'hA5C3;
    for (int i = 2*W-1; i >= 0; i--) step(pat[i], 1'b1, 1'b0, 1'b1, 1'b0);
    tag = "R3";
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);

    // R2: serial input wiggles without shift strobe
    tag = "R2";
    for (int i = 0; i < 4; i++) step(i[0], 1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);

    // R4: shift and latch together
    tag = "R4";
    pat = 16'h3C96;
    for (int i = 0; i < 2*W; i++) step(pat[i], 1'b1, i[1], 1'b1, 1'b0);

    // R5 R6: clear mid-stream with shift high keeps outputs
    tag = "R6";
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    tag = "R5";
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);

    // R8: enable released during shifting, state unaffected
    tag = "R8";
    pat = 16'hF00F;
    for (int i = 0; i < 2*W; i++) step(pat[i], 1'b1, 1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);

    // R1 R3: walking one
    tag = "R1";
    for (int i = 0; i < 2*W; i++) step(i == 0, 1'b1, 1'b0, 1'b1, 1'b0);
    tag = "R3";
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule